// File: doc/BRIEF.md
# DMA Completion Interrupt Vector Unit

This unit collects completion events from a set of transmit DMA channels and a set of receive DMA channels. It also collects two miscellaneous sources, a host-error event and a status event. All of them are folded into a single encoded vector word and one interrupt line for the host processor. Each event arrives as a one-cycle pulse and is held in a per-source pending flag. The flag stays set until the host acknowledges that source. A per-source enable decides whether a pending flag takes part in the vector and the line.

The host services an interrupt in four steps. It reads the vector, which reports the lowest-numbered active channel of each direction. It acknowledges the channels it has handled. It then writes the end-of-interrupt strobe. The line stays asserted from its rising edge until that strobe, whatever the host acknowledges in the meantime. After the strobe the line is held low for two cycles, and it rises again only if enabled work is still pending.

Enables are written through separate set masks and clear masks, so one write never disturbs the other bits. All host-side pins are plain single-cycle strobes with their data. There is no streaming interface, so there is no back-pressure.

Top module: `dma_irq_vector`

## Requirements
- R1: After reset the vector reads 0, the interrupt line is low, and every pending flag and enable bit is clear.
- R2: Vector bit 16 is 1 when any transmit channel is both pending and enabled. Bits 2:0 then hold the lowest such channel number, and they hold 0 otherwise.
- R3: Vector bit 17 is 1 when any receive channel is both pending and enabled. Bits 10:8 then hold the lowest such channel number, and they hold 0 otherwise.
- R4: Vector bit 18 reports a pending host error, gated by misc enable bit 0. Vector bit 19 reports a pending status event, gated by misc enable bit 1. All other vector bits read 0.
- R5: A 1 in a set mask turns that channel's enable on, and a 1 in a clear mask turns it off. When both hit the same channel in one cycle, the clear wins. A disabled channel still latches its events but is absent from the vector and the line, and it shows up once it is enabled.
- R6: An acknowledge strobe with a channel number clears that channel's pending flag at the next edge. An event on the same channel in the same cycle wins, and the flag stays set.
- R7: The interrupt line rises one cycle after an enabled source becomes pending, while the line is armed. Once high it stays high until an end-of-interrupt strobe, even if every source is acknowledged.
- R8: An end-of-interrupt strobe drives the line low at the next edge and keeps it low for the following cycle as well. After that, the line rises again only if an enabled source is pending.
- R9: A misc acknowledge mask clears the host-error flag with bit 0 and the status flag with bit 1. An event arriving in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | 8 | Per-channel transmit completion pulses |
| rx_done | input | 8 | Per-channel receive completion pulses |
| host_err | input | 1 | Host error event pulse |
| stat_evt | input | 1 | Status event pulse |
| tx_en_set | input | 8 | Transmit enable set mask (one-cycle write) |
| tx_en_clr | input | 8 | Transmit enable clear mask (one-cycle write) |
| rx_en_set | input | 8 | Receive enable set mask |
| rx_en_clr | input | 8 | Receive enable clear mask |
| misc_en_we | input | 1 | Write strobe for the misc enable pair |
| misc_en_val | input | 2 | Misc enables: bit 0 host error, bit 1 status |
| tx_ack_we | input | 1 | Transmit acknowledge strobe |
| tx_ack_ch | input | 3 | Transmit channel being acknowledged |
| rx_ack_we | input | 1 | Receive acknowledge strobe |
| rx_ack_ch | input | 3 | Receive channel being acknowledged |
| misc_ack | input | 2 | Misc acknowledge mask |
| eoi_we | input | 1 | End-of-interrupt strobe |
| vector | output | 32 | Encoded interrupt vector |
| irq | output | 1 | Interrupt line to the host |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an acknowledge and a fresh completion event on the same channel. The second is the end-of-interrupt strobe with work still pending, where the re-arm gap must not swallow or shorten the next assertion. The bench drives the event pulse and the acknowledge strobe on the same clock edge, then reads the vector to see that the channel survived. An acknowledge aimed at one channel, paired with an event on a different channel, is read back to show that each side took effect. For the second pair, the line is sampled on each of the three cycles after the strobe and must read low, low, high.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int VEC_W       = 32;
  localparam int FIELD_W     = 3;
  localparam int TX_IDX_LSB  = 0;
  localparam int RX_IDX_LSB  = 8;
  localparam int TX_FLAG_BIT = 16;
  localparam int RX_FLAG_BIT = 17;
  localparam int HE_FLAG_BIT = 18;
  localparam int ST_FLAG_BIT = 19;
  localparam int MISC_N      = 2;
  localparam int MISC_HE     = 0;
  localparam int MISC_ST     = 1;
endpackage

// File: rtl/ivu_lowest.sv
module ivu_lowest #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/ivu_chan_bank.sv
module ivu_chan_bank #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en_set,
  input  logic [N-1:0] en_clr,
  input  logic         ack_we,
  input  logic [W-1:0] ack_ch,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic         act_any,
  output logic [W-1:0] act_idx
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] pend_q, en_q, ack_vec, active;

  assign ack_vec = ack_we ? (ONE << ack_ch) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_vec) | evt;
      en_q   <= (en_q | en_set) & ~en_clr;
    end
  end

  assign active = pend_q & en_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;

  ivu_lowest #(.N(N), .W(W)) u_low (
    .req   (active),
    .found (act_any),
    .idx   (act_idx)
  );
endmodule

// File: rtl/ivu_irq_ctrl.sv
module ivu_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_active,
  input  logic eoi_we,
  output logic irq
);
  logic irq_q, gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      gap_q <= 1'b0;
    end else if (eoi_we) begin
      irq_q <= 1'b0;
      gap_q <= 1'b1;
    end else if (gap_q) begin
      gap_q <= 1'b0;
    end else if (any_active) begin
      irq_q <= 1'b1;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/dma_irq_vector.sv
module dma_irq_vector
  import ivu_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   tx_done,
  input  logic [N_CH-1:0]   rx_done,
  input  logic              host_err,
  input  logic              stat_evt,
  input  logic [N_CH-1:0]   tx_en_set,
  input  logic [N_CH-1:0]   tx_en_clr,
  input  logic [N_CH-1:0]   rx_en_set,
  input  logic [N_CH-1:0]   rx_en_clr,
  input  logic              misc_en_we,
  input  logic [1:0]        misc_en_val,
  input  logic              tx_ack_we,
  input  logic [CH_W-1:0]   tx_ack_ch,
  input  logic              rx_ack_we,
  input  logic [CH_W-1:0]   rx_ack_ch,
  input  logic [1:0]        misc_ack,
  input  logic              eoi_we,
  output logic [VEC_W-1:0]  vector,
  output logic              irq
);
  logic [N_CH-1:0]   tx_pend, tx_en, rx_pend, rx_en;
  logic              tx_any, rx_any;
  logic [CH_W-1:0]   tx_idx, rx_idx;
  logic [MISC_N-1:0] misc_pend_q, misc_en_q, misc_act, misc_evt;

  ivu_chan_bank #(.N(N_CH), .W(CH_W)) u_tx (
    .clk, .rst_n,
    .evt     (tx_done),
    .en_set  (tx_en_set),
    .en_clr  (tx_en_clr),
    .ack_we  (tx_ack_we),
    .ack_ch  (tx_ack_ch),
    .pend_o  (tx_pend),
    .en_o    (tx_en),
    .act_any (tx_any),
    .act_idx (tx_idx)
  );

  ivu_chan_bank #(.N(N_CH), .W(CH_W)) u_rx (
    .clk, .rst_n,
    .evt     (rx_done),
    .en_set  (rx_en_set),
    .en_clr  (rx_en_clr),
    .ack_we  (rx_ack_we),
    .ack_ch  (rx_ack_ch),
    .pend_o  (rx_pend),
    .en_o    (rx_en),
    .act_any (rx_any),
    .act_idx (rx_idx)
  );

  assign misc_evt[MISC_HE] = host_err;
  assign misc_evt[MISC_ST] = stat_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_pend_q <= '0;
      misc_en_q   <= '0;
    end else begin
      misc_pend_q <= (misc_pend_q & ~misc_ack) | misc_evt;
      if (misc_en_we) misc_en_q <= misc_en_val;
    end
  end

  assign misc_act = misc_pend_q & misc_en_q;

  always_comb begin
    vector = '0;
    vector[TX_FLAG_BIT] = tx_any;
    vector[RX_FLAG_BIT] = rx_any;
    vector[HE_FLAG_BIT] = misc_act[MISC_HE];
    vector[ST_FLAG_BIT] = misc_act[MISC_ST];
    vector[TX_IDX_LSB +: FIELD_W] = FIELD_W'(tx_idx);
    vector[RX_IDX_LSB +: FIELD_W] = FIELD_W'(rx_idx);
  end

  ivu_irq_ctrl u_irq (
    .clk, .rst_n,
    .any_active (tx_any | rx_any | (|misc_act)),
    .eoi_we     (eoi_we),
    .irq        (irq)
  );
endmodule

// File: rtl/dma_irq_vector_chk.sv
module dma_irq_vector_chk #(
  parameter int N_CH = 8,
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] tx_done,
  input logic            tx_ack_we,
  input logic [CH_W-1:0] tx_ack_ch,
  input logic            eoi_we,
  input logic [31:0]     vector,
  input logic            irq,
  input logic [N_CH-1:0] tx_pend,
  input logic [N_CH-1:0] tx_en
);
  localparam logic [N_CH-1:0] ONE = {{(N_CH-1){1'b0}}, 1'b1};
  logic [N_CH-1:0] tx_act, below;
  assign tx_act = tx_pend & tx_en;
  assign below  = (ONE << vector[2:0]) - ONE;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !eoi_we |=> irq); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(vector[19:16] != 4'b0)); // R7
  AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we |=> !irq); // R8
  AST_EOI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we |-> ##2 !irq); // R8
  AST_TX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    vector[16] |-> (tx_act[vector[2:0]] && ((tx_act & below) == '0))); // R2
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vector[16] |-> (vector[2:0] == 3'd0 && tx_act == '0)); // R2
  AST_TX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack_we && !tx_done[tx_ack_ch] |=> !tx_pend[$past(tx_ack_ch)]); // R6

  for (genvar g = 0; g < N_CH; g++) begin : g_latch
    AST_TX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done[g] |=> tx_pend[g]); // R5
  end
endmodule

bind dma_irq_vector dma_irq_vector_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk, .rst_n, .tx_done, .tx_ack_we, .tx_ack_ch, .eoi_we,
  .vector, .irq, .tx_pend, .tx_en
);

// File: tb/sim_dma_irq_vector.sv
module sim_dma_irq_vector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_done = '0, rx_done = '0;
  logic host_err = 1'b0, stat_evt = 1'b0;
  logic [7:0] tx_en_set = '0, tx_en_clr = '0, rx_en_set = '0, rx_en_clr = '0;
  logic misc_en_we = 1'b0;
  logic [1:0] misc_en_val = '0;
  logic tx_ack_we = 1'b0, rx_ack_we = 1'b0;
  logic [2:0] tx_ack_ch = '0, rx_ack_ch = '0;
  logic [1:0] misc_ack = '0;
  logic eoi_we = 1'b0;
  logic [31:0] vector;
  logic irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma_irq_vector u0 (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_done = '0; rx_done = '0; host_err = 0; stat_evt = 0;
    tx_en_set = '0; tx_en_clr = '0; rx_en_set = '0; rx_en_clr = '0;
    misc_en_we = 0; tx_ack_we = 0; rx_ack_we = 0; misc_ack = '0; eoi_we = 0;
  endtask

  task automatic cleanup();
    for (int c = 0; c < 8; c++) begin
      tx_ack_we = 1; tx_ack_ch = 3'(c); rx_ack_we = 1; rx_ack_ch = 3'(c);
      step();
    end
    idle_inputs();
    misc_ack = 2'b11; eoi_we = 1; step();
    idle_inputs(); step(); step();
  endtask

  task automatic t_reset();
    chk("R1 vector", vector, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_tx_lowest();
    tx_en_set = 8'hFF; step(); idle_inputs();
    tx_done = 8'b0010_1000; step(); idle_inputs();
    chk("R2 lowest tx", vector, 32'h0001_0003);
    chk("R7 irq not yet", {31'b0, irq}, 32'h0);
    step();
    chk("R7 irq rises", {31'b0, irq}, 32'h1);
    tx_ack_we = 1; tx_ack_ch = 3'd3; step(); idle_inputs();
    chk("R6 ack moves to next", vector, 32'h0001_0005);
    tx_ack_we = 1; tx_ack_ch = 3'd5; step(); idle_inputs();
    chk("R2 none pending", vector, 32'h0);
    chk("R7 irq held without pending", {31'b0, irq}, 32'h1);
    eoi_we = 1; step(); idle_inputs();
    chk("R8 eoi drops", {31'b0, irq}, 32'h0);
    step(); step();
    chk("R8 stays low when idle", {31'b0, irq}, 32'h0);
    cleanup();
  endtask

  task automatic t_rx_and_tx();
    rx_en_set = 8'hFF; tx_en_set = 8'hFF; step(); idle_inputs();
    rx_done = 8'b0100_0100; tx_done = 8'h80; step(); idle_inputs();
    chk("R3 rx field with tx", vector, 32'h0003_0207);
    rx_ack_we = 1; rx_ack_ch = 3'd2; step(); idle_inputs();
    chk("R3 next rx", vector, 32'h0003_0607);
    cleanup();
  endtask

  task automatic t_mask();
    tx_en_set = 8'hFF; step(); idle_inputs();
    tx_en_clr = 8'h02; step(); idle_inputs();
    tx_done = 8'h02; step(); idle_inputs();
    chk("R5 disabled hidden", vector, 32'h0);
    step();
    chk("R5 disabled no irq", {31'b0, irq}, 32'h0);
    tx_en_set = 8'h04; tx_en_clr = 8'h04; step(); idle_inputs();
    tx_done = 8'h04; step(); idle_inputs();
    chk("R5 clear wins over set", vector, 32'h0);
    tx_en_set = 8'h02; step(); idle_inputs();
    chk("R5 revealed on enable", vector, 32'h0001_0001);
    cleanup();
  endtask

  task automatic t_misc();
    misc_en_we = 1; misc_en_val = 2'b01; step(); idle_inputs();
    host_err = 1; stat_evt = 1; step(); idle_inputs();
    chk("R4 host only enabled", vector, 32'h0004_0000);
    misc_en_we = 1; misc_en_val = 2'b11; step(); idle_inputs();
    chk("R4 both enabled", vector, 32'h000C_0000);
    misc_ack = 2'b01; step(); idle_inputs();
    chk("R9 host acked", vector, 32'h0008_0000);
    misc_ack = 2'b10; stat_evt = 1; step(); idle_inputs();
    chk("R9 event beats ack", vector, 32'h0008_0000);
    misc_ack = 2'b10; step(); idle_inputs();
    chk("R9 status acked", vector, 32'h0);
    cleanup();
    misc_en_we = 1; misc_en_val = 2'b00; step(); idle_inputs();
  endtask

  task automatic t_same_cycle();
    tx_en_set = 8'hFF; step(); idle_inputs();
    tx_done = 8'h10; step(); idle_inputs();
    tx_done = 8'h10; tx_ack_we = 1; tx_ack_ch = 3'd4; step(); idle_inputs();
    chk("R6 event wins over ack", vector, 32'h0001_0004);
    tx_done = 8'h01; tx_ack_we = 1; tx_ack_ch = 3'd4; step(); idle_inputs();
    chk("R6 ack other channel", vector, 32'h0001_0000);
    tx_ack_we = 1; tx_ack_ch = 3'd0; step(); idle_inputs();
    chk("R6 all cleared", vector, 32'h0);
    cleanup();
  endtask

  task automatic t_reassert();
    rx_en_set = 8'hFF; step(); idle_inputs();
    rx_done = 8'h08; step(); idle_inputs();
    step();
    chk("R7 irq up", {31'b0, irq}, 32'h1);
    eoi_we = 1; step(); idle_inputs();
    chk("R8 low after eoi", {31'b0, irq}, 32'h0);
    step();
    chk("R8 gap cycle", {31'b0, irq}, 32'h0);
    step();
    chk("R8 reasserts with pending", {31'b0, irq}, 32'h1);
    cleanup();
  endtask

  initial begin
    idle_inputs();
    step(); step();
    rst_n = 1; step();
    t_reset();
    t_tx_lowest();
    t_rx_and_tx();
    t_mask();
    t_misc();
    t_same_cycle();
    t_reassert();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule